// File: doc/BRIEF.md
# Flash Array Program and Erase Unit

This block owns the byte-wide storage array of a serial NOR flash model and sits behind the command sequencer. The array holds sector size times sector count bytes. The sequencer hands it two kinds of work. A program request writes one byte at a running address. An erase request carries a kind code and a start address, and the block fills the chosen region with 0xFF.

Programming can only clear bits: the stored byte becomes the old value ANDed with the new one. A build parameter lets the new byte replace the old one outright, so the array can stand in for an EEPROM. Erase writes one byte per cycle and holds `busy` high while it runs. Capability parameters state which small erase sizes the part supports. An unsupported size, or work requested while write-enable is clear, raises a one-cycle error pulse. Reads go through a combinational port that is always available.

Top module: `flash_pe_array`

## Requirements
- R1: After reset every array byte reads 0xFF, and `busy`, `cap_err` and `wp_err` are low.
- R2: With `REWRITE_ONES` = 0, an accepted program byte leaves the stored byte equal to old AND `prog_data`.
- R3: An accepted program byte writes at `addr_in` when `addr_load` is high in the same cycle, and at the running address otherwise. The running address then becomes the written address plus one, modulo the array size. `addr_load` alone only sets the running address.
- R4: A program byte accepted while `wr_enable` is low is still written, and `wp_err` is high for the following cycle.
- R5: An erase request while `wr_enable` is low is dropped. `busy` stays low, the array is unchanged, and `wp_err` is high for the following cycle.
- R6: `erase_kind` selects the region length. 0 selects 4096 bytes, 1 selects 32768 bytes, 2 selects `SECTOR_BYTES`, and 3 selects the whole array starting at address 0, ignoring `erase_addr`. `busy` rises after the accepting edge and stays high for exactly one cycle per erased byte.
- R7: For kinds 0 to 2, the erase starts at `erase_addr` exactly as given, with no alignment. Bytes before the start are untouched.
- R8: An erase region that would run past the last array byte stops at that byte. Bytes below the start address are unaffected.
- R9: A kind 0 request when `CAN_4K` = 0, or a kind 1 request when `CAN_32K` = 0, pulses `cap_err` for one cycle. If `wr_enable` is high, the erase is still performed.
- R10: While `busy` is high, program and erase requests are ignored. A program request does not change the array and does not advance the running address.
- R11: When an erase and a program request arrive together while idle, the erase is taken. The program byte is dropped and the running address does not advance.
- R12: With `REWRITE_ONES` = 1, an accepted program byte replaces the stored byte, so bits can return to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; fills the array with 0xFF |
| wr_enable | input | 1 | Write-enable state from the sequencer |
| addr_load | input | 1 | Load `addr_in` as the running program address |
| addr_in | input | AW | Program start address |
| prog_valid | input | 1 | Program one byte |
| prog_data | input | 8 | Byte to program |
| erase_valid | input | 1 | Erase request |
| erase_kind | input | 2 | 0 = 4 KiB, 1 = 32 KiB, 2 = sector, 3 = whole array |
| erase_addr | input | AW | Erase start address |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Array byte at `rd_addr` (combinational) |
| busy | output | 1 | Erase in progress |
| cap_err | output | 1 | One-cycle pulse: erase size not supported |
| wp_err | output | 1 | One-cycle pulse: request while write-enable is clear |

## Verification
A program byte and the start of an erase can meet in one idle cycle. The bench provokes this by loading a program address first and then raising `prog_valid` in the same cycle as an erase request, with the load outside the erase region. It judges the result from the ports alone: the erase must last its full length, the loaded byte must still read 0xFF, and the next unloaded program byte must land at that same address. The same method covers requests made while `busy` is high. The bench injects a program and a whole-array erase mid-run, then confirms the run length is unchanged and the following program byte lands at the loaded address.

// File: rtl/flash_pe_array.sv
module flash_pe_array #(
  parameter int SECTOR_BYTES = 512,
  parameter int SECTOR_COUNT = 4,
  parameter bit CAN_4K       = 1'b1,
  parameter bit CAN_32K      = 1'b0,
  parameter bit REWRITE_ONES = 1'b0,
  localparam int SIZE = SECTOR_BYTES * SECTOR_COUNT,
  localparam int AW   = $clog2(SIZE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_enable,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          prog_valid,
  input  logic [7:0]    prog_data,
  input  logic          erase_valid,
  input  logic [1:0]    erase_kind,
  input  logic [AW-1:0] erase_addr,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          cap_err,
  output logic          wp_err
);

  localparam int LASTI = SIZE - 1;

  logic [7:0]    mem [SIZE];
  logic [AW-1:0] pa, eptr, elast;
  logic [31:0]   elen, ewide;
  logic [AW-1:0] estart, eclip;

  wire erase_go  = erase_valid && !busy;
  wire erase_run = erase_go && wr_enable;
  wire prog_go   = prog_valid && !busy && !erase_valid;
  wire [AW-1:0] prog_at = addr_load ? addr_in : pa;
  wire kind_bad  = (erase_kind == 2'd0 && !CAN_4K) || (erase_kind == 2'd1 && !CAN_32K);

  always_comb begin
    case (erase_kind)
      2'd0:    elen = 32'd4096;
      2'd1:    elen = 32'd32768;
      2'd2:    elen = 32'(SECTOR_BYTES);
      default: elen = 32'(SIZE);
    endcase
  end

  assign estart  = (erase_kind == 2'd3) ? '0 : erase_addr;
  assign ewide   = 32'(estart) + elen - 32'd1;
  assign eclip   = (ewide > 32'(LASTI)) ? AW'(LASTI) : ewide[AW-1:0];
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SIZE; i++) mem[i] <= 8'hFF;
    end else if (busy) begin
      mem[eptr] <= 8'hFF;
    end else if (prog_go) begin
      mem[prog_at] <= REWRITE_ONES ? prog_data : (mem[prog_at] & prog_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      eptr    <= '0;
      elast   <= '0;
      pa      <= '0;
      cap_err <= 1'b0;
      wp_err  <= 1'b0;
    end else begin
      cap_err <= erase_go && kind_bad;
      wp_err  <= (erase_go || prog_go) && !wr_enable;
      if (erase_run) begin
        busy  <= 1'b1;
        eptr  <= estart;
        elast <= eclip;
      end else if (busy) begin
        if (eptr == elast) busy <= 1'b0;
        else eptr <= eptr + 1'b1;
      end
      if (prog_go) pa <= prog_at + 1'b1;
      else if (addr_load) pa <= addr_in;
    end
  end

  assert_wp_erase_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_valid && !busy && !wr_enable) |=> !busy);

  assert_erase_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_valid && !busy && wr_enable) |=> busy);

  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eptr != elast) |=> busy);

  assert_ptr_in_region_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (eptr <= elast));

  assert_cap_from_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_err |-> $past(erase_valid));

  assert_busy_prog_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prog_valid && !addr_load) |=> $stable(pa));

  assert_collision_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && erase_valid && prog_valid && !addr_load) |=> $stable(pa));

endmodule

// File: tb/flash_pe_array_bench.sv
`timescale 1ns/1ps
module flash_pe_array_bench;
  localparam int SB = 1024, SC = 8, SIZE = SB * SC, AW = $clog2(SIZE);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, wr_enable = 1'b0, addr_load = 1'b0, prog_valid = 1'b0, erase_valid = 1'b0;
  logic [AW-1:0] addr_in = '0, erase_addr = '0, rd_addr = '0;
  logic [7:0] prog_data = '0, rd_data;
  logic [1:0] erase_kind = '0;
  logic busy, cap_err, wp_err;

  flash_pe_array #(.SECTOR_BYTES(SB), .SECTOR_COUNT(SC), .CAN_4K(1'b1), .CAN_32K(1'b0),
                   .REWRITE_ONES(1'b0)) u_flash_pe_array (
    .clk(clk), .rst_n(rst_n), .wr_enable(wr_enable), .addr_load(addr_load), .addr_in(addr_in),
    .prog_valid(prog_valid), .prog_data(prog_data), .erase_valid(erase_valid),
    .erase_kind(erase_kind), .erase_addr(erase_addr), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .cap_err(cap_err), .wp_err(wp_err));

  logic r_load = 1'b0, r_prog = 1'b0;
  logic [10:0] r_addr = '0, r_rd = '0;
  logic [7:0] r_data = '0, r_q;
  logic r_busy, r_cap, r_wp;

  flash_pe_array #(.REWRITE_ONES(1'b1)) u_flash_pe_array_rw (
    .clk(clk), .rst_n(rst_n), .wr_enable(1'b1), .addr_load(r_load), .addr_in(r_addr),
    .prog_valid(r_prog), .prog_data(r_data), .erase_valid(1'b0), .erase_kind(2'd0),
    .erase_addr(11'd0), .rd_addr(r_rd), .rd_data(r_q), .busy(r_busy), .cap_err(r_cap),
    .wp_err(r_wp));

  int checks = 0, errors = 0;
  typedef struct { int a; int v; string tag; } exp_t;
  exp_t q[$];
  logic [7:0] model [SIZE];
  int mptr = 0;

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_byte(int a, string tag);
    exp_t e;
    e.a = a; e.v = int'(model[a]); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        rd_addr = AW'(e.a);
        #1;
        chk(int'(rd_data), e.v, e.tag);
      end
    end
  end

  task automatic prog(int a, logic [7:0] d);
    if (a >= 0) begin addr_load = 1'b1; addr_in = AW'(a); mptr = a; end
    prog_valid = 1'b1; prog_data = d;
    @(negedge clk);
    addr_load = 1'b0; prog_valid = 1'b0;
    model[mptr] = model[mptr] & d;
    mptr = (mptr + 1) % SIZE;
  endtask

  task automatic erase(int kind, int a, int exp_len, int exp_cap, bit inject, bit collide, string tag);
    int cnt, st, en;
    erase_valid = 1'b1; erase_kind = 2'(kind); erase_addr = AW'(a);
    if (collide) begin prog_valid = 1'b1; prog_data = 8'h00; end
    @(negedge clk);
    erase_valid = 1'b0; prog_valid = 1'b0;
    chk(int'(cap_err), exp_cap, {tag, " cap_err"});
    chk(int'(wp_err), int'(!wr_enable), {tag, " wp_err"});
    cnt = 0;
    while (busy) begin
      if (inject && cnt == 10) begin
        addr_load = 1'b1; addr_in = AW'(12'hFF0); prog_valid = 1'b1; prog_data = 8'h00;
        erase_valid = 1'b1; erase_kind = 2'd3;
        mptr = 12'hFF0;
      end
      @(negedge clk);
      addr_load = 1'b0; prog_valid = 1'b0; erase_valid = 1'b0;
      cnt++;
    end
    chk(cnt, exp_len, {tag, " busy length"});
    if (exp_len > 0) begin
      st = (kind == 3) ? 0 : a;
      en = st + exp_len;
      for (int i = st; i < en; i++) model[i] = 8'hFF;
    end
  endtask

  initial begin
    #(4ns * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < SIZE; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(busy), 0, "R1 busy after reset");
    chk(int'(cap_err | wp_err), 0, "R1 error pulses after reset");
    expect_byte(0, "R1 byte 0"); expect_byte(4000, "R1 byte 4000"); expect_byte(SIZE-1, "R1 last byte");
    drain();

    wr_enable = 1'b1;
    prog(16'h10, 8'hA5); chk(int'(wp_err), 0, "R2 no wp_err");
    prog(-1, 8'h3C);
    prog(16'h10, 8'h0F);
    expect_byte(16'h10, "R2 AND of A5 and 0F"); expect_byte(16'h11, "R3 advanced address");
    drain();

    wr_enable = 1'b0;
    prog(16'h20, 8'h12); chk(int'(wp_err), 1, "R4 wp_err on program");
    expect_byte(16'h20, "R4 program applied with write-enable clear");
    drain();

    erase(2, 0, 0, 0, 0, 0, "R5 protected erase");
    expect_byte(16'h10, "R5 array unchanged"); expect_byte(16'h20, "R5 array unchanged 2");
    drain();

    wr_enable = 1'b1;
    prog(16'h08, 8'h00); prog(-1, 8'h00); prog(-1, 8'h00); prog(-1, 8'h00);
    prog(16'h40C, 8'h00);
    erase(2, 16'h0C, SB, 0, 0, 0, "R6 sector erase");
    expect_byte(16'h0B, "R7 byte before unaligned start"); expect_byte(16'h0C, "R7 start byte");
    expect_byte(16'h40B, "R6 last sector byte"); expect_byte(16'h40C, "R6 byte after sector");
    drain();

    prog(16'h10FF, 8'h00); prog(-1, 8'h00);
    erase(0, 16'h100, 4096, 0, 0, 0, "R6 4K erase");
    expect_byte(16'h10FF, "R6 4K last byte"); expect_byte(16'h1100, "R6 after 4K region");
    expect_byte(16'h0B, "R7 below 4K start");
    drain();

    prog(16'h0FFF, 8'h00);
    erase(1, 16'h1000, SIZE - 16'h1000, 1, 1, 0, "R9 R8 R10 32K erase clipped");
    expect_byte(16'h0FFF, "R8 below start kept"); expect_byte(16'h1100, "R9 still erased");
    expect_byte(SIZE-1, "R8 last byte"); expect_byte(16'h0FF0, "R10 busy program ignored");
    drain();
    prog(-1, 8'h77);
    expect_byte(16'h0FF0, "R10 address not advanced while busy"); expect_byte(16'h0FF1, "R10 neighbour");
    drain();

    addr_load = 1'b1; addr_in = AW'(16'h0FF1); mptr = 16'h0FF1;
    @(negedge clk); addr_load = 1'b0;
    erase(2, 16'h1400, SB, 0, 0, 1, "R11 collision erase");
    expect_byte(16'h0FF1, "R11 program dropped");
    drain();
    prog(-1, 8'h11);
    expect_byte(16'h0FF1, "R11 address not advanced");
    drain();

    erase(3, 16'h123, SIZE, 0, 0, 0, "R6 whole array");
    expect_byte(0, "R6 whole array byte 0"); expect_byte(16'h0FF1, "R6 whole array mid");
    expect_byte(SIZE-1, "R6 whole array last");
    drain();

    r_load = 1'b1; r_addr = 11'd5; r_prog = 1'b1; r_data = 8'h00;
    @(negedge clk);
    r_data = 8'h0F;
    @(negedge clk);
    r_load = 1'b0; r_prog = 1'b0; r_rd = 11'd5;
    #1;
    chk(int'(r_q), 8'h0F, "R12 rewrite sets ones");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule